// File: doc/BRIEF.md
# Maskable Interrupt Priority Arbiter

This block keeps a small control register for every maskable interrupt source. Each register holds a priority level and a pending flag. A hardware event strobe from the source sets the pending flag. Software reads the register over a simple byte-wide bus and may clear the flag, but it can never set it. In every cycle the block looks at all pending sources. It keeps only those whose level is strictly above the CPU's current priority level, and a level of zero always drops the source. From the survivors it picks one winner, and it offers that winner to the CPU's interrupt sequencer when the CPU's interrupt-enable flag is set.

The winner leaves the block as a valid/ready stream carrying the source number and its level. The offer is recomputed every cycle, so `win_valid` may fall without a handshake when the CPU raises its level, clears its enable flag, or software withdraws the request. The sequencer takes the offer by holding `win_ready` high in a cycle where `win_valid` is high. That handshake clears the pending flag of the offered source. The sequencer must read `win_src` and `win_lvl` only in the handshake cycle. Fetching the vector and stacking the context happen outside this block.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset every source register reads 8'h00 and `win_valid` is 0.
- R2: A register reads as {4'b0000, pending, level[2:0]}. Bits 2:0 hold the level, bit 3 holds the pending flag, and bits 7:4 always read 0 whatever value was written.
- R3: An event strobe on a source sets that source's pending flag, and the flag can be read back in the next cycle.
- R4: A register write with bit 3 = 0 clears the pending flag. A write with bit 3 = 1 leaves the flag unchanged, so it never sets it. Bits 2:0 of every write load the level.
- R5: When an event strobe and a clearing write reach the same source in the same cycle, the pending flag ends up set.
- R6: A source with level 0 is never offered.
- R7: A source is offered only while it is pending, its level is strictly greater than `cpu_ipl`, and `cpu_ie` is 1.
- R8: Among the eligible sources the highest level wins. When levels tie, the lowest source index wins.
- R9: The offer is registered. It reflects the register state and the CPU inputs of the previous cycle, so a change of `cpu_ipl` masks the offer from the next cycle on.
- R10: A handshake (`win_valid` and `win_ready` both high) clears the pending flag of `win_src`. In the next cycle that source is not offered again, and the next eligible source is offered instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_SRC | Per-source event strobes; each one sets that source's pending flag |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | SRC_W | Index of the source register to write or read |
| reg_wdata | input | 8 | Write data (bit 3 pending, bits 2:0 level) |
| reg_rdata | output | 8 | Read data of the addressed register, combinational |
| cpu_ie | input | 1 | CPU interrupt-enable flag |
| cpu_ipl | input | 3 | CPU current priority level |
| win_valid | output | 1 | An accept request is offered |
| win_ready | input | 1 | The sequencer takes the offer |
| win_src | output | SRC_W | Index of the offered source |
| win_lvl | output | 3 | Level of the offered source |

## Verification
The results come due at different times:
- A register write or an event strobe shows up on the combinational read port one cycle after the edge that captures it.
- An event shows up on the offer two edges after it is driven: one edge to set the flag and one edge to register the winner.
- A change of `cpu_ipl` or `cpu_ie`, and a handshake, change the offer after exactly one edge.

The bench drives its inputs on falling edges and samples on the falling edge that follows the edge at which the result is due. In the level-masking test it also samples once before that edge, to show the old offer is still held there.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W  = 3;
  localparam int REG_W  = 8;
  localparam int PND_BIT = 3;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [REG_W-1:0] reg_t;

  function automatic reg_t pack_reg(input logic pend, input lvl_t lvl);
    reg_t r;
    r = '0;
    r[LVL_W-1:0] = lvl;
    r[PND_BIT]   = pend;
    return r;
  endfunction
endpackage

// File: rtl/irq_src_ctl.sv
module irq_src_ctl
  import irq_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic wr_hit,
  input  reg_t wdata,
  input  logic acc_clr,
  output logic pend,
  output lvl_t lvl
);
  logic sw_clr;
  assign sw_clr = wr_hit && !wdata[PND_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      lvl  <= '0;
    end else begin
      if (wr_hit) lvl <= wdata[LVL_W-1:0];
      if (evt)                   pend <= 1'b1;
      else if (sw_clr || acc_clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]            pend,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
  input  logic [NUM_SRC-1:0]            excl,
  input  logic                          cpu_ie,
  input  lvl_t                          cpu_ipl,
  output logic                          any,
  output logic [SRC_W-1:0]              src,
  output lvl_t                          best
);
  logic [NUM_SRC-1:0] elig;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = pend[i] && !excl[i] && (lvl[i] > cpu_ipl);
  end

  logic hit;
  always_comb begin
    hit  = 1'b0;
    src  = '0;
    best = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (lvl[i] > best)) begin
        hit  = 1'b1;
        src  = SRC_W'(i);
        best = lvl[i];
      end
    end
  end

  assign any = hit && cpu_ie;
endmodule

// File: rtl/irq_win_reg.sv
module irq_win_reg
  import irq_arb_pkg::*;
#(
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nxt_valid,
  input  logic [SRC_W-1:0] nxt_src,
  input  lvl_t             nxt_lvl,
  output logic             q_valid,
  output logic [SRC_W-1:0] q_src,
  output lvl_t             q_lvl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_src   <= '0;
      q_lvl   <= '0;
    end else begin
      q_valid <= nxt_valid;
      q_src   <= nxt_valid ? nxt_src : '0;
      q_lvl   <= nxt_valid ? nxt_lvl : '0;
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               reg_wr_en,
  input  logic [SRC_W-1:0]   reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               cpu_ie,
  input  logic [2:0]         cpu_ipl,
  output logic               win_valid,
  input  logic               win_ready,
  output logic [SRC_W-1:0]   win_src,
  output logic [2:0]         win_lvl
);
  logic [NUM_SRC-1:0]            req_q;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
  logic [NUM_SRC-1:0]            acc_clr;
  logic                          take;

  assign take = win_valid && win_ready;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic hit;
    assign hit        = reg_wr_en && (reg_addr == SRC_W'(i));
    assign acc_clr[i] = take && (win_src == SRC_W'(i));

    irq_src_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_i[i]),
      .wr_hit  (hit),
      .wdata   (reg_wdata),
      .acc_clr (acc_clr[i]),
      .pend    (req_q[i]),
      .lvl     (lvl_q[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reg_addr == SRC_W'(i)) reg_rdata = pack_reg(req_q[i], lvl_q[i]);
    end
  end

  logic             nxt_valid;
  logic [SRC_W-1:0] nxt_src;
  lvl_t             nxt_lvl;

  irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend    (req_q),
    .lvl     (lvl_q),
    .excl    (acc_clr),
    .cpu_ie  (cpu_ie),
    .cpu_ipl (cpu_ipl),
    .any     (nxt_valid),
    .src     (nxt_src),
    .best    (nxt_lvl)
  );

  irq_win_reg #(.SRC_W(SRC_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_valid (nxt_valid),
    .nxt_src   (nxt_src),
    .nxt_lvl   (nxt_lvl),
    .q_valid   (win_valid),
    .q_src     (win_src),
    .q_lvl     (win_lvl)
  );
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               reg_wr_en,
  input logic [SRC_W-1:0]   reg_addr,
  input logic [7:0]         reg_wdata,
  input logic [7:0]         reg_rdata,
  input logic               cpu_ie,
  input logic [2:0]         cpu_ipl,
  input logic               win_valid,
  input logic               win_ready,
  input logic [SRC_W-1:0]   win_src,
  input logic [2:0]         win_lvl,
  input logic [NUM_SRC-1:0] req_q
);
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:4] == 4'b0000);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_r3
    assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[k] |=> req_q[k]);
  end

  assert_sw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_wdata[3] && !evt_i[reg_addr]) |=> !req_q[$past(reg_addr)]);

  assert_evt_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && evt_i[reg_addr]) |=> req_q[$past(reg_addr)]);

  assert_lvl_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> win_lvl != 3'd0);

  assert_above_ipl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> ($past(cpu_ie) && (win_lvl > $past(cpu_ipl))));

  assert_take_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ready && !evt_i[win_src]) |=> !req_q[$past(win_src)]);

  assert_no_reoffer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ready) |=> !(win_valid && win_src == $past(win_src)));
endmodule

bind irq_prio_arbiter irq_arb_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .cpu_ie    (cpu_ie),
  .cpu_ipl   (cpu_ipl),
  .win_valid (win_valid),
  .win_ready (win_ready),
  .win_src   (win_src),
  .win_lvl   (win_lvl),
  .req_q     (req_q)
);

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
  localparam int N  = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_i = '0;
  logic          reg_wr_en = 1'b0;
  logic [SW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          cpu_ie = 1'b0;
  logic [2:0]    cpu_ipl = '0;
  logic          win_valid;
  logic          win_ready = 1'b0;
  logic [SW-1:0] win_src;
  logic [2:0]    win_lvl;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_prio_arbiter #(.NUM_SRC(N)) u_irq_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_ie(cpu_ie), .cpu_ipl(cpu_ipl), .win_valid(win_valid),
    .win_ready(win_ready), .win_src(win_src), .win_lvl(win_lvl)
  );

  typedef struct packed {
    logic [23:0] lv;
    logic [7:0]  msk;
    logic [2:0]  ipl;
    logic        ie;
    logic        ev;
    logic [2:0]  es;
    logic [2:0]  el;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{24'h000000, 8'hFF, 3'd0, 1'b1, 1'b0, 3'd0, 3'd0},
    '{24'h000A00, 8'h08, 3'd0, 1'b1, 1'b1, 3'd3, 3'd5},
    '{24'h1B0020, 8'h62, 3'd2, 1'b1, 1'b1, 3'd5, 3'd6},
    '{24'h1B0020, 8'h62, 3'd2, 1'b0, 1'b0, 3'd0, 3'd0},
    '{24'h0000C0, 8'h04, 3'd3, 1'b1, 1'b0, 3'd0, 3'd0},
    '{24'h0000C0, 8'h04, 3'd2, 1'b1, 1'b1, 3'd2, 3'd3},
    '{24'hFFFFFF, 8'h80, 3'd6, 1'b1, 1'b1, 3'd7, 3'd7},
    '{24'hE00001, 8'h81, 3'd7, 1'b1, 1'b0, 3'd0, 3'd0},
    '{24'h002002, 8'h11, 3'd1, 1'b1, 1'b1, 3'd0, 3'd2},
    '{24'h001C00, 8'h10, 3'd0, 1'b1, 1'b1, 3'd4, 3'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = SW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    evt_i = m;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = SW'(a);
    #1 d = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 32'(win_valid), 32'd0);
    for (int i = 0; i < N; i++) begin
      rd(i, d);
      check("R1 reg after reset", 32'(d), 32'h00);
    end

    wr(2, 8'hFB);
    rd(2, d);
    check("R2 R4 upper zero, write 1 no set", 32'(d), 32'h03);
    pulse(8'h04);
    rd(2, d);
    check("R3 event sets pending", 32'(d), 32'h0B);
    wr(2, 8'h03);
    rd(2, d);
    check("R4 write 0 clears", 32'(d), 32'h03);

    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h03; evt_i = 8'h04;
    @(negedge clk);
    reg_wr_en = 1'b0; evt_i = '0;
    rd(2, d);
    check("R5 event beats clear", 32'(d), 32'h0B);

    @(negedge clk);
    cpu_ie = 1'b1; cpu_ipl = 3'd0;
    @(negedge clk);
    check("R7 offer valid", 32'(win_valid), 32'd1);
    check("R7 offer src", 32'(win_src), 32'd2);
    cpu_ipl = 3'd3;
    #1 check("R9 old offer held before edge", 32'(win_valid), 32'd1);
    @(negedge clk);
    check("R9 equal ipl masks next cycle", 32'(win_valid), 32'd0);

    cpu_ipl = 3'd0;
    wr(5, 8'h01);
    pulse(8'h20);
    @(negedge clk);
    check("R8 higher level wins src", 32'(win_src), 32'd2);
    check("R8 higher level wins lvl", 32'(win_lvl), 32'd3);
    win_ready = 1'b1;
    @(negedge clk);
    win_ready = 1'b0;
    check("R10 next valid", 32'(win_valid), 32'd1);
    check("R10 next src", 32'(win_src), 32'd5);
    check("R10 next lvl", 32'(win_lvl), 32'd1);
    rd(2, d);
    check("R10 taken source cleared", 32'(d), 32'h03);

    foreach (VECS[v]) begin
      @(negedge clk);
      cpu_ie = VECS[v].ie; cpu_ipl = VECS[v].ipl;
      for (int i = 0; i < N; i++) wr(i, {5'b0, VECS[v].lv[3*i +: 3]});
      pulse(VECS[v].msk);
      @(negedge clk);
      check("R6 R7 R8 R9 table valid", 32'(win_valid), 32'(VECS[v].ev));
      if (VECS[v].ev) begin
        check("R8 table src", 32'(win_src), 32'(VECS[v].es));
        check("R8 table lvl", 32'(win_lvl), 32'(VECS[v].el));
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule